// File: doc/BRIEF.md
# Latched Serial-to-Parallel Polarity Driver

This block turns a serial bit stream into a set of parallel channel levels. Bits arrive as a valid/ready stream and move through a chain of stages, one stage per accepted beat. A hold register with an active-low capture control sits after the chain. While the control is low, the hold register is transparent and the channels track the chain at once. While it is high, the channels keep the last captured pattern, whatever is shifted in behind it.

An active-low polarity control either passes the held pattern to the channels or inverts every channel. A separate backplane line switches with the polarity control, so a segment and its common electrode can be driven in opposite phase. The polarity path is purely combinational.

The last stage of the chain is repeated on a cascade output so that devices can be chained. The cascade output updates one clock after the shift that produced its value. The next device therefore samples a value that has been stable for a full cycle. A `casc_valid` pulse marks each update, and it can drive the next device's `in_valid`. The input never applies back-pressure: `in_ready` is high whenever reset is low, and a beat is accepted on every clock edge where `in_valid` and `in_ready` are both high.

Top module: `sp_polarity_driver`

## Requirements
- R1: A synchronous reset clears the shift chain, the hold register, `casc_bit` and `casc_valid` to 0. `in_ready` is 0 while `rst` is high.
- R2: Each accepted beat moves stage k to stage k+1 and loads `in_bit` into stage 1, which is `chan_out[0]`. A clock edge with no accepted beat leaves the chain unchanged.
- R3: `in_ready` is 1 in every cycle in which `rst` is 0, so the input never back-pressures.
- R4: The first bit accepted after reset reaches the last stage, `chan_out[NCH-1]`, after exactly NCH accepted beats, and not after NCH-1 beats.
- R5: While `le_n` is 0, the hold stage is transparent: the channels reflect the chain contents in the same cycle, including a shift made on the preceding edge.
- R6: While `le_n` is 1, the channels keep the chain value as it stood after the last edge at which `le_n` was 0, even while beats keep shifting.
- R7: With `pol_n` = 1, each `chan_out[i]` equals its held bit and `bp_out` = 0. With `pol_n` = 0, each `chan_out[i]` is the inverse of its held bit and `bp_out` = 1.
- R8: A change on `pol_n` reaches `chan_out` and `bp_out` within the same cycle, without any clock edge.
- R9: On the edge one clock after an accepted beat, `casc_bit` takes the value of the last stage and `casc_valid` is 1 for that cycle. In all other cycles, `casc_bit` holds its value and `casc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Serial beat offered |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_bit | input | 1 | Serial data bit of the beat |
| le_n | input | 1 | Hold control, active low: low = transparent, high = hold |
| pol_n | input | 1 | Polarity control, active low: low = invert channels |
| chan_out | output | NCH | Parallel channel levels; bit NCH-1 is the last stage |
| bp_out | output | 1 | Backplane line, high in invert mode |
| casc_bit | output | 1 | Cascade data for the next device's in_bit |
| casc_valid | output | 1 | One-cycle pulse on each cascade update |

## Verification
The assertions assume that `rst`, `in_valid`, `in_bit`, `le_n` and `pol_n` are synchronous to `clk` and stable around its rising edge. They also assume that `rst` is held high for at least one edge before any property is relied on. The stimulus drives every input 2 ns after a rising edge and never near the next one. The only exception is `pol_n`, which is also toggled in the middle of a cycle to exercise the combinational polarity path; no clocked property samples `pol_n`. Because beats are never refused, the stimulus may present `in_valid` in any pattern, including long bursts and idle gaps.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int unsigned SP_CHANNELS_DEFAULT = 16;

  typedef enum logic {
    POL_PASS   = 1'b0,
    POL_INVERT = 1'b1
  } pol_mode_e;

endpackage

// File: rtl/sp_shift_chain.sv
module sp_shift_chain #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);

  logic [W-1:0] stage_q;

  always_comb begin
    q_next = stage_q;
    if (shift_en) q_next = {stage_q[W-2:0], din};
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= q_next;
  end

  assign q = stage_q;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (stage_q == '0));

  p_shift_move_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (stage_q[0] == $past(din)) && (stage_q[W-1:1] == $past(stage_q[W-2:0])));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stage_q));

endmodule

// File: rtl/sp_hold_latch.sv
module sp_hold_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le_n,
  input  logic [W-1:0] chain_now,
  input  logic [W-1:0] chain_next,
  output logic [W-1:0] view
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)        held_q <= '0;
    else if (!le_n) held_q <= chain_next;
  end

  // low: the chain shows through; high: the captured copy is shown
  assign view = le_n ? held_q : chain_now;

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    !le_n |=> (held_q == chain_now));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    le_n |=> $stable(held_q));

endmodule

// File: rtl/sp_polarity.sv
module sp_polarity #(
  parameter int unsigned W = 16
) (
  input  logic         pol_n,
  input  logic [W-1:0] view,
  output logic [W-1:0] chan_out,
  output logic         bp_out
);
  import sp_pkg::*;

  pol_mode_e mode;
  logic      flip;

  assign mode   = pol_n ? POL_PASS : POL_INVERT;
  assign flip   = (mode == POL_INVERT);
  assign bp_out = (mode == POL_INVERT);

  for (genvar i = 0; i < W; i++) begin : g_chan
    assign chan_out[i] = view[i] ^ flip;
  end

  always_comb begin
    if (bp_out) p_invert_r7: assert (chan_out == ~view);
    else        p_pass_r7:   assert (chan_out == view);
  end

endmodule

// File: rtl/sp_cascade.sv
module sp_cascade (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic tail,
  output logic casc_bit,
  output logic casc_valid
);

  logic shifted_q;
  logic bit_q;
  logic vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shifted_q <= 1'b0;
      bit_q     <= 1'b0;
      vld_q     <= 1'b0;
    end else begin
      shifted_q <= shift_en;
      vld_q     <= shifted_q;
      if (shifted_q) bit_q <= tail;
    end
  end

  assign casc_bit   = bit_q;
  assign casc_valid = vld_q;

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!casc_valid && !casc_bit));

  p_lag_bit_r9: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ##1 (casc_valid && (casc_bit == $past(tail))));

  p_steady_r9: assert property (@(posedge clk) disable iff (rst)
    !casc_valid |-> $stable(casc_bit));

endmodule

// File: rtl/sp_polarity_driver.sv
module sp_polarity_driver #(
  parameter int unsigned NCH = sp_pkg::SP_CHANNELS_DEFAULT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_bit,
  input  logic           le_n,
  input  logic           pol_n,
  output logic [NCH-1:0] chan_out,
  output logic           bp_out,
  output logic           casc_bit,
  output logic           casc_valid
);

  localparam int unsigned LAST = NCH - 1;

  logic           accept;
  logic [NCH-1:0] chain_q;
  logic [NCH-1:0] chain_d;
  logic [NCH-1:0] view;

  assign in_ready = !rst;
  assign accept   = in_valid && in_ready;

  sp_shift_chain #(.W(NCH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (accept),
    .din      (in_bit),
    .q        (chain_q),
    .q_next   (chain_d)
  );

  sp_hold_latch #(.W(NCH)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .le_n       (le_n),
    .chain_now  (chain_q),
    .chain_next (chain_d),
    .view       (view)
  );

  sp_polarity #(.W(NCH)) u_pol (
    .pol_n    (pol_n),
    .view     (view),
    .chan_out (chan_out),
    .bp_out   (bp_out)
  );

  sp_cascade u_casc (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (accept),
    .tail       (chain_q[LAST]),
    .casc_bit   (casc_bit),
    .casc_valid (casc_valid)
  );

  p_no_backpressure_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> in_ready);

endmodule

// File: tb/tb_sp_polarity_driver.sv
module tb_sp_polarity_driver;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_bit = 1'b0;
  logic         le_n = 1'b0;
  logic         pol_n = 1'b1;
  logic [N-1:0] chan_out;
  logic         bp_out;
  logic         casc_bit;
  logic         casc_valid;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // reference model state
  bit m_chain[N];
  bit m_hold[N];
  bit m_casc = 0;
  bit m_cvld = 0;
  bit m_shifted = 0;

  always #4 clk = ~clk;

  sp_polarity_driver #(.NCH(N)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .le_n(le_n), .pol_n(pol_n), .chan_out(chan_out),
    .bp_out(bp_out), .casc_bit(casc_bit), .casc_valid(casc_valid)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_chain[i] = 0; m_hold[i] = 0; end
      m_casc = 0; m_cvld = 0; m_shifted = 0;
    end else begin
      m_cvld = m_shifted;
      if (m_shifted) m_casc = m_chain[N-1];
      m_shifted = in_valid;
      if (in_valid) begin
        for (int i = N-1; i > 0; i--) m_chain[i] = m_chain[i-1];
        m_chain[0] = in_bit;
      end
      if (!le_n) for (int i = 0; i < N; i++) m_hold[i] = m_chain[i];
    end
  end

  function automatic logic [N-1:0] exp_chan();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (le_n ? m_hold[i] : m_chain[i]) ^ !pol_n;
    return v;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check(rst ? "R1 chan" : (le_n ? "R6 chan" : "R5 chan"), chan_out, exp_chan());
      check("R7 bp", {{(N-1){1'b0}}, bp_out}, {{(N-1){1'b0}}, !pol_n});
      check(rst ? "R1 casc_bit" : "R9 casc_bit", {{(N-1){1'b0}}, casc_bit}, {{(N-1){1'b0}}, m_casc});
      check(rst ? "R1 casc_valid" : "R9 casc_valid", {{(N-1){1'b0}}, casc_valid}, {{(N-1){1'b0}}, m_cvld});
      check(rst ? "R1 ready" : "R3 ready", {{(N-1){1'b0}}, in_ready}, {{(N-1){1'b0}}, !rst});
    end
  end

  task automatic step(bit v, bit b);
    @(posedge clk); #2;
    in_valid = v; in_bit = b;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    chk_on = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R4: a single 1 walks to the last stage in exactly N beats
    step(1, 1);
    for (int k = 1; k < N - 1; k++) step(1, 0);
    step(0, 0);
    #1 check("R4 after N-1 beats", {15'd0, chan_out[N-1]}, 16'd0);
    step(1, 0);
    step(0, 0);
    #1 check("R4 after N beats", {15'd0, chan_out[N-1]}, 16'd1);
    step(0, 0);
    step(0, 0);
    #1 check("R9 cascade carries last stage", {15'd0, casc_bit}, 16'd1);

    // R2: gaps leave chain alone
    step(0, 1);
    step(0, 1);
    #1 check("R2 idle no shift", chan_out, exp_chan());

    // mixed traffic, transparent
    for (int k = 0; k < 200; k++) step(($urandom % 4) != 0, $urandom % 2);

    // R6: hold while shifting
    step(0, 0);
    @(posedge clk); #2 le_n = 1'b1;
    for (int k = 0; k < 40; k++) step(1, $urandom % 2);
    #1 check("R6 held while shifting", chan_out, exp_chan());
    @(posedge clk); #2 le_n = 1'b0;
    @(posedge clk); #2 le_n = 1'b1;
    for (int k = 0; k < 20; k++) step($urandom % 2, $urandom % 2);

    // R7 / R8: polarity changes mid-cycle
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #1 pol_n = ~pol_n;
      #1 check("R8 polarity immediate", chan_out, exp_chan());
      check("R8 bp immediate", {15'd0, bp_out}, {15'd0, !pol_n});
      in_valid = $urandom % 2; in_bit = $urandom % 2;
      le_n = ($urandom % 3) == 0;
    end

    // random everything
    for (int k = 0; k < 600; k++) begin
      @(posedge clk); #2;
      in_valid = ($urandom % 3) != 0; in_bit = $urandom % 2;
      if (($urandom % 8) == 0) le_n = ~le_n;
      if (($urandom % 10) == 0) pol_n = ~pol_n;
    end

    // R1: reset mid-run
    @(posedge clk); #2 rst = 1'b1; pol_n = 1'b1;
    step(1, 1);
    step(1, 1);
    #1 check("R1 cleared", chan_out, 16'd0);
    @(posedge clk); #2 rst = 1'b0;
    for (int k = 0; k < 50; k++) step($urandom % 2, $urandom % 2);

    step(0, 0);
    @(posedge clk);
    @(negedge clk);
    chk_on = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule